// File: doc/BRIEF.md
# Event Interval Capture Timer

This block measures the elapsed time between successive asynchronous external events, such as the peaks found by an external peak picker on a physiological waveform. A free-running counter advances by one on every cycle in which a fixed-rate tick enable is high. With a 10 kHz tick this gives 0.1 ms resolution, and the 16-bit default width covers intervals of more than 1.5 s without ambiguity.

The event input is not synchronous to the clock. It passes through a synchronizer, and each rising edge produces a single-cycle capture pulse. On a capture the block latches the current count. It then forms the interval as the new count minus the previously latched count, and keeps the new count as the reference for the next event. A sticky flag marks each fresh interval. The consumer reads `interval_o` and then clears the flag with a one-cycle strobe. Because the capture takes only a few clock cycles, an event is always recorded well inside one tick period, so no tick is lost.

Top module: `evt_interval_timer`

## Requirements
- R1: While `rst_ni` is low, and right after it goes high, `interval_o`, `capture_o` and `fresh_o` are all 0 and the internal count is 0.
- R2: The internal count advances by exactly one at each rising clock edge where `tick_i` is high, wraps from 0xFFFF to 0x0000, and holds otherwise.
- R3: Let edge k be a rising clock edge at which `event_i` is sampled high, and edge k-1 the edge before it, at which it was sampled low. At edge k+2 the count value present just before that edge is copied into `capture_o`.
- R4: On every capture after the first one since reset, `interval_o` becomes the new capture value minus the previous capture value.
- R5: The subtraction is modulo 2^16, so an interval that spans a counter wrap is still correct.
- R6: Every capture after the first one since reset sets `fresh_o` to 1. It stays 1 until a cycle in which `clear_i` is high and no such capture occurs.
- R7: The first capture after reset only loads the reference: `fresh_o` is not set and `interval_o` stays 0.
- R8: When a capture that sets the flag coincides with `clear_i`, `fresh_o` ends up 1.
- R9: An event held high causes only one capture. Without a new rising edge, `capture_o` and `interval_o` hold, and so does a cleared `fresh_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base enable; the count advances when high |
| event_i | input | 1 | Asynchronous event input; the rising edge triggers a capture |
| clear_i | input | 1 | One-cycle strobe from the consumer that clears `fresh_o` |
| interval_o | output | 16 | Latest interval, in ticks |
| capture_o | output | 16 | Count latched at the latest event |
| fresh_o | output | 1 | A new interval is available |

## Verification
On every cycle the assertions check four things:
- the stickiness of the flag and the priority of set over clear;
- that the first capture leaves the flag low;
- that the interval equals the difference between the new capture and the previous one;
- that the outputs hold between capture pulses, and that each pulse lasts one cycle.

Some behaviours only the bench scenarios can show:
- the exact three-edge capture latency measured from the raw input;
- the counter's tick gating and its reset value, which are visible only through captured values;
- an interval that spans the full 16-bit wrap, which needs about 65 000 ticks of stimulus.

// File: rtl/eit_pkg.sv
package eit_pkg;
  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DEF_STAGES = 2;

  typedef enum logic {
    REF_EMPTY  = 1'b0,
    REF_LOADED = 1'b1
  } ref_state_e;
endpackage

// File: rtl/eit_edge_sync.sv
module eit_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[STAGES-1];
  end

  assign pulse_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/eit_tick_counter.sv
module eit_tick_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (tick_i) count_q <= count_q + ONE;  // wraps naturally
  end

  assign count_o = count_q;
endmodule

// File: rtl/eit_capture.sv
module eit_capture
  import eit_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] interval_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             fresh_o,
  output logic             primed_o
);
  ref_state_e       ref_q;
  logic [CNT_W-1:0] ref_cnt_q;
  logic [CNT_W-1:0] interval_q;
  logic             fresh_q;
  logic             set_fresh;

  assign set_fresh = pulse_i && (ref_q == REF_LOADED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q      <= REF_EMPTY;
      ref_cnt_q  <= '0;
      interval_q <= '0;
    end else if (pulse_i) begin
      ref_q     <= REF_LOADED;
      ref_cnt_q <= count_i;
      if (ref_q == REF_LOADED) interval_q <= count_i - ref_cnt_q;  // mod 2^W
    end
  end

  // Set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fresh_q <= 1'b0;
    else if (set_fresh) fresh_q <= 1'b1;
    else if (clear_i)   fresh_q <= 1'b0;
  end

  assign interval_o = interval_q;
  assign capture_o  = ref_cnt_q;
  assign fresh_o    = fresh_q;
  assign primed_o   = (ref_q == REF_LOADED);
endmodule

// File: rtl/evt_interval_timer.sv
module evt_interval_timer #(
  parameter int unsigned CNT_W  = eit_pkg::DEF_CNT_W,
  parameter int unsigned STAGES = eit_pkg::DEF_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             event_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] interval_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             fresh_o
);
  logic             evt_pulse;
  logic             ref_vld;
  logic [CNT_W-1:0] count;

  eit_edge_sync #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(event_i),
    .pulse_o(evt_pulse)
  );

  eit_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .count_o(count)
  );

  eit_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pulse_i   (evt_pulse),
    .count_i   (count),
    .clear_i   (clear_i),
    .interval_o(interval_o),
    .capture_o (capture_o),
    .fresh_o   (fresh_o),
    .primed_o  (ref_vld)
  );
endmodule

// File: rtl/eit_checks.sv
module eit_checks #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             pulse_i,
  input logic             primed_i,
  input logic [CNT_W-1:0] interval_i,
  input logic [CNT_W-1:0] capture_i,
  input logic             fresh_i
);
  AST_FRESH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fresh_i && !clear_i |=> fresh_i);  // R6

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i && primed_i |=> fresh_i);  // R8

  AST_FIRST_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fresh_i && !(pulse_i && primed_i) |=> !fresh_i);  // R7

  AST_INTERVAL_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i && primed_i |=> interval_i == CNT_W'(capture_i - $past(capture_i)));  // R4

  AST_HOLD_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> $stable(capture_i) && $stable(interval_i));  // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> !pulse_i);  // R3
endmodule

bind evt_interval_timer eit_checks #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clear_i   (clear_i),
  .pulse_i   (evt_pulse),
  .primed_i  (ref_vld),
  .interval_i(interval_o),
  .capture_i (capture_o),
  .fresh_i   (fresh_o)
);

// File: tb/evt_interval_timer_tb_top.sv
module evt_interval_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        event_i = 1'b0;
  logic        clear_i = 1'b0;
  logic [15:0] interval_o;
  logic [15:0] capture_o;
  logic        fresh_o;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  // reference state
  logic [15:0] m_cnt = '0;
  logic [15:0] m_ref = '0;
  logic [15:0] m_int = '0;
  logic        m_fresh = 1'b0;
  logic        m_have = 1'b0;
  logic [2:0]  m_hist = '0;

  always #4 clk_i = ~clk_i;

  evt_interval_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .event_i(event_i),
    .clear_i(clear_i), .interval_o(interval_o), .capture_o(capture_o),
    .fresh_o(fresh_o)
  );

  function automatic logic [15:0] wrap_sub(logic [15:0] a, logic [15:0] b);
    return a - b;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, update model on posedge, compare after
  task automatic step(input logic tk, input logic ev, input logic cl);
    logic rise;
    @(negedge clk_i);
    tick_i = tk; event_i = ev; clear_i = cl;
    @(posedge clk_i);
    rise = m_hist[1] & ~m_hist[2];  // three-edge capture latency, R3
    m_hist = {m_hist[1:0], ev};
    if (rise) begin
      if (m_have) begin
        m_int   = wrap_sub(m_cnt, m_ref);
        m_fresh = 1'b1;
      end else if (cl) m_fresh = 1'b0;
      m_ref  = m_cnt;
      m_have = 1'b1;
    end else if (cl) m_fresh = 1'b0;
    if (tk) m_cnt = m_cnt + 16'd1;  // R2
    #1;
    check("R2/R3 capture", capture_o, m_ref);
    check("R4 interval", interval_o, m_int);
    check("R6 fresh", {15'd0, fresh_o}, {15'd0, m_fresh});
  endtask

  task automatic pulse_event(input int hi, input int lo, input logic tk);
    for (int i = 0; i < hi; i++) step(tk, 1'b1, 1'b0);
    for (int i = 0; i < lo; i++) step(tk, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-reqs actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] cap_hold;
    void'($urandom(32'd7341));
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 reset interval", interval_o, 16'd0);
    check("R1 reset capture", capture_o, 16'd0);
    check("R1 reset fresh", {15'd0, fresh_o}, 16'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // counter starts at 0: 5 ticks then first event, R1/R2
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
    pulse_event(3, 4, 1'b0);
    check("R1 count from zero", capture_o, 16'd5);
    check("R7 first no flag", {15'd0, fresh_o}, 16'd0);
    check("R7 first interval zero", interval_o, 16'd0);

    // second event: interval equals ticks between, R4
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 1'b0);
    pulse_event(2, 4, 1'b0);
    check("R4 directed interval", interval_o, 16'd9);
    check("R6 flag set", {15'd0, fresh_o}, 16'd1);
    step(1'b0, 1'b0, 1'b1);
    check("R6 flag cleared", {15'd0, fresh_o}, 16'd0);

    // held event: one capture only, R9
    cap_hold = capture_o;
    pulse_event(1, 0, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0);
    check("R9 no recapture flag", {15'd0, fresh_o}, 16'd0);
    check("R9 capture held", capture_o, wrap_sub(cap_hold, 16'd0) + 16'd2);
    pulse_event(0, 4, 1'b0);

    // set beats clear in the same cycle, R8
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    check("R8 set over clear", {15'd0, fresh_o}, 16'd1);
    pulse_event(0, 4, 1'b0);

    // random phase
    for (int n = 0; n < 400; n++) begin
      int hi = 1 + ($urandom % 5);
      int lo = 1 + ($urandom % 8);
      for (int i = 0; i < hi + lo; i++)
        step(($urandom % 3) != 0, i < hi, ($urandom % 6) == 0);
    end

    // wrap: capture near top, next after wrap, R5
    while (m_cnt != 16'hFFF0) step(1'b1, 1'b0, 1'b0);
    pulse_event(2, 2, 1'b1);
    cap_hold = capture_o;
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0);
    pulse_event(2, 2, 1'b1);
    check("R5 wrap interval", interval_o, wrap_sub(capture_o, cap_hold));
    check("R5 wrap span", interval_o, 16'd34);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule